// File: doc/BRIEF.md
# Clock Controller Divider Register Bank

This block is the programmable register file of a clock generator. Software reaches it through a simple word-addressed bus with combinational read data. It holds the loop multiplier, a pre-divider, a post-divider, an oscillator divider, a bypass divider, up to nine system clock dividers, a clock gate register and a GO command/status pair. The oscillator, the muxing of clocks and glitch-free switching sit outside. This block supplies the division factors, enables and multiplier that drive them.

The system clock dividers are double-buffered. Bus writes land in a shadow copy. A GO command captures every shadow at once into a pending set. After a fixed, parameterised number of cycles, which stands for alignment to the slowest divider, all pending ratios move together into the active set that drives the outputs. A busy flag is high for the whole transfer. Software may keep writing shadows during a transfer, and those writes wait for the next GO. The four auxiliary dividers (pre, post, oscillator, bypass), the multiplier and the clock gates take effect as soon as they are written. A parameter selects a second multiplier convention: twice the field value instead of the field plus one.

Top module: `clkgen_div_bank`

## Requirements
- R1: After reset every system and auxiliary divider reads back ratio 0 with enable set (0x0000_8000), every division output is 1 with its enable high, the multiplier field reads 0 (factor 1), both clock gates are low and the busy flag is low.
- R2: The bus address is the byte offset divided by four. System divider n sits at byte 0x118+4*(n-1) for n = 1..3 and at byte 0x160+4*(n-4) for n = 4..9. Each of the nine reads back its own value.
- R3: A divider register keeps its ratio in bits [4:0] and its enable in bit 15. All other bits read 0. The division output equals the ratio plus one.
- R4: A write to a system divider changes only its readback. The active division and enable outputs stay unchanged until a GO transfer completes.
- R5: Writing 1 to bit 0 of the command register (byte 0x138) while idle raises busy on the next cycle. Busy stays high for exactly GO_CYCLES cycles. When busy falls, every system divider output takes the shadow value present when the GO was accepted.
- R6: A system divider write made during a transfer does not alter the values that transfer commits. It reads back at once and reaches the outputs at the next GO.
- R7: A GO command written while busy is ignored and does not lengthen the transfer.
- R8: Bit 0 of the status register (byte 0x13C) reads the busy flag, and all its other bits read 0. The command register always reads 0.
- R9: The pre (0x114), post (0x128), oscillator (0x124) and bypass (0x12C) dividers drive their outputs from the cycle after the write, with no GO.
- R10: The multiplier register (byte 0x110) keeps a MULT_W-bit field, and the upper bits read 0. With DOUBLE_MODE=0 the multiplier output equals the field plus one.
- R11: In the clock gate register (byte 0x148), bit 0 drives the auxiliary clock gate and bit 1 drives the observation clock gate, both from the cycle after the write.
- R12: Reads of unmapped offsets return 0. Writes to them change no register and no output.
- R13: The control register (byte 0x100) stores the full data word. The observation select register (byte 0x104) stores bits [4:0]. The revision register (byte 0x000) reads the REV_ID parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (byte offset / 4) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| sys_divide | output | NUM_SYS*(RATIO_W+1) | Active division factor per system divider, divider 1 in the low slice |
| sys_enable | output | NUM_SYS | Active enable per system divider |
| fix_divide | output | 4*(RATIO_W+1) | Division factor of pre, post, oscillator, bypass dividers, in that order from the low slice |
| fix_enable | output | 4 | Enables of the same four dividers |
| mult_factor | output | MULT_W+1 | Loop multiplication factor |
| aux_gate_en | output | 1 | Auxiliary clock gate |
| obs_gate_en | output | 1 | Observation clock gate |
| go_busy | output | 1 | GO transfer in progress |

## Verification
The assertions assume single-cycle bus accesses with known address and control, and that rst_n is held for at least one edge before the first access. The bench drives each access for exactly one clock, between falling edges, and never leaves bus_sel high across a reset. GO requests that arrive during a busy window are issued deliberately, so the fixed-length window check also covers requests that must be ignored. The bench samples the combinational read data one nanosecond after it drives the address.

// File: rtl/clkgen_div_pkg.sv
package clkgen_div_pkg;

   // Bit position of the enable flag inside every divider word
   localparam int unsigned ENA_BIT = 15;
   localparam int unsigned OSEL_W  = 5;
   localparam int unsigned NUM_FIX = 4;

   // Word addresses (byte offset >> 2)
   localparam logic [7:0] W_REV    = 8'h00;
   localparam logic [7:0] W_CTL    = 8'h40;
   localparam logic [7:0] W_OSEL   = 8'h41;
   localparam logic [7:0] W_MULT   = 8'h44;
   localparam logic [7:0] W_PRE    = 8'h45;
   localparam logic [7:0] W_OSC    = 8'h49;
   localparam logic [7:0] W_POST   = 8'h4A;
   localparam logic [7:0] W_BYP    = 8'h4B;
   localparam logic [7:0] W_CMD    = 8'h4E;
   localparam logic [7:0] W_STAT   = 8'h4F;
   localparam logic [7:0] W_CKEN   = 8'h52;
   localparam logic [7:0] W_SYS_LO = 8'h46;  // system dividers 1..3
   localparam logic [7:0] W_SYS_HI = 8'h58;  // system dividers 4..9

   // Slot order of the auxiliary dividers on fix_divide / fix_enable
   typedef enum int {
      FIX_PRE  = 0,
      FIX_POST = 1,
      FIX_OSC  = 2,
      FIX_BYP  = 3
   } fix_slot_e;

   typedef struct packed {
      logic rev;
      logic ctl;
      logic osel;
      logic mult;
      logic cmd;
      logic stat;
      logic cken;
   } misc_hit_t;

   // idx is zero-based: system divider idx+1
   function automatic logic [7:0] sys_word(input int idx);
      if (idx < 3) return W_SYS_LO + 8'(idx);
      else         return W_SYS_HI + 8'(idx - 3);
   endfunction

   function automatic logic [7:0] fix_word(input int idx);
      case (idx)
         FIX_PRE:  return W_PRE;
         FIX_POST: return W_POST;
         FIX_OSC:  return W_OSC;
         default:  return W_BYP;
      endcase
   endfunction

endpackage

// File: rtl/clkgen_addr_dec.sv
module clkgen_addr_dec
   import clkgen_div_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned NUM_SYS = 9
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_SYS-1:0] sys_hit,
   output logic [NUM_FIX-1:0] fix_hit,
   output misc_hit_t          misc
);

   for (genvar i = 0; i < NUM_SYS; i++) begin : g_sys
      assign sys_hit[i] = (addr == ADDR_W'(sys_word(i)));
   end

   for (genvar j = 0; j < NUM_FIX; j++) begin : g_fix
      assign fix_hit[j] = (addr == ADDR_W'(fix_word(j)));
   end

   assign misc.rev  = (addr == ADDR_W'(W_REV));
   assign misc.ctl  = (addr == ADDR_W'(W_CTL));
   assign misc.osel = (addr == ADDR_W'(W_OSEL));
   assign misc.mult = (addr == ADDR_W'(W_MULT));
   assign misc.cmd  = (addr == ADDR_W'(W_CMD));
   assign misc.stat = (addr == ADDR_W'(W_STAT));
   assign misc.cken = (addr == ADDR_W'(W_CKEN));

endmodule

// File: rtl/clkgen_div_slot.sv
module clkgen_div_slot #(
   parameter int unsigned RATIO_W = 5,
   parameter bit          STAGED  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [RATIO_W-1:0] wr_ratio,
   input  logic               wr_enable,
   input  logic               snap,
   input  logic               commit,
   output logic [RATIO_W-1:0] rd_ratio,
   output logic               rd_enable,
   output logic [RATIO_W:0]   divide,
   output logic               act_enable
);

   logic [RATIO_W-1:0] sh_ratio;
   logic               sh_en;
   logic [RATIO_W-1:0] act_ratio;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_ratio <= '0;
         sh_en    <= 1'b1;
      end else if (wr_en) begin
         sh_ratio <= wr_ratio;
         sh_en    <= wr_enable;
      end
   end

   if (STAGED) begin : g_staged
      logic [RATIO_W-1:0] pend_ratio;
      logic               pend_en;
      logic [RATIO_W-1:0] live_ratio;
      logic               live_en;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_ratio <= '0;
            pend_en    <= 1'b1;
         end else if (snap) begin
            pend_ratio <= sh_ratio;
            pend_en    <= sh_en;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live_ratio <= '0;
            live_en    <= 1'b1;
         end else if (commit) begin
            live_ratio <= pend_ratio;
            live_en    <= pend_en;
         end
      end

      assign act_ratio  = live_ratio;
      assign act_enable = live_en;
   end else begin : g_direct
      logic unused_tie;
      assign unused_tie = ^{snap, commit};
      assign act_ratio  = sh_ratio;
      assign act_enable = sh_en;
   end

   assign rd_ratio  = sh_ratio;
   assign rd_enable = sh_en;
   assign divide    = {1'b0, act_ratio} + {{RATIO_W{1'b0}}, 1'b1};

endmodule

// File: rtl/clkgen_go_seq.sv
module clkgen_go_seq #(
   parameter int unsigned GO_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_req,
   output logic busy,
   output logic snap,
   output logic commit
);

   localparam int unsigned CNT_W = (GO_CYCLES < 2) ? 1 : $clog2(GO_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   assign snap   = go_req & ~busy_q;
   assign commit = busy_q & (cnt_q == '0);
   assign busy   = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (snap) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(GO_CYCLES - 1);
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/clkgen_mult_calc.sv
module clkgen_mult_calc #(
   parameter int unsigned MULT_W      = 5,
   parameter bit          DOUBLE_MODE = 1'b0
) (
   input  logic [MULT_W-1:0] field,
   output logic [MULT_W:0]   factor
);

   if (DOUBLE_MODE) begin : g_double
      assign factor = {field, 1'b0};
   end else begin : g_plus_one
      assign factor = {1'b0, field} + {{MULT_W{1'b0}}, 1'b1};
   end

endmodule

// File: rtl/clkgen_div_bank.sv
module clkgen_div_bank
   import clkgen_div_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_SYS     = 9,
   parameter int unsigned RATIO_W     = 5,
   parameter int unsigned MULT_W      = 5,
   parameter int unsigned GO_CYCLES   = 8,
   parameter bit          DOUBLE_MODE = 1'b0,
   parameter logic [31:0] REV_ID      = 32'h5C1A_0103
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            bus_sel,
   input  logic                            bus_wr,
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic [DATA_W-1:0]               bus_wdata,
   output logic [DATA_W-1:0]               bus_rdata,
   output logic [NUM_SYS*(RATIO_W+1)-1:0]  sys_divide,
   output logic [NUM_SYS-1:0]              sys_enable,
   output logic [NUM_FIX*(RATIO_W+1)-1:0]  fix_divide,
   output logic [NUM_FIX-1:0]              fix_enable,
   output logic [MULT_W:0]                 mult_factor,
   output logic                            aux_gate_en,
   output logic                            obs_gate_en,
   output logic                            go_busy
);

   localparam int unsigned DIV_W = RATIO_W + 1;

   initial begin
      if (NUM_SYS < 1 || NUM_SYS > 9)
         $fatal(1, "NUM_SYS must lie in 1..9");
      if (RATIO_W < 2 || RATIO_W > ENA_BIT)
         $fatal(1, "RATIO_W must lie in 2..15");
      if (DATA_W < ENA_BIT + 1)
         $fatal(1, "DATA_W must hold the enable bit");
      if (MULT_W < 1 || MULT_W > DATA_W)
         $fatal(1, "MULT_W out of range");
      if (ADDR_W < 8)
         $fatal(1, "ADDR_W must be at least 8");
      if (GO_CYCLES < 1)
         $fatal(1, "GO_CYCLES must be at least 1");
   end

   // ---------------- decode ----------------
   logic [NUM_SYS-1:0] sys_hit;
   logic [NUM_FIX-1:0] fix_hit;
   misc_hit_t          misc;
   logic               wr_cyc;

   clkgen_addr_dec #(
      .ADDR_W (ADDR_W),
      .NUM_SYS(NUM_SYS)
   ) u_dec (
      .addr   (bus_addr),
      .sys_hit(sys_hit),
      .fix_hit(fix_hit),
      .misc   (misc)
   );

   assign wr_cyc = bus_sel & bus_wr;

   // ---------------- GO sequencer ----------------
   logic go_req, snap, commit, busy;

   assign go_req = wr_cyc & misc.cmd & bus_wdata[0];

   clkgen_go_seq #(
      .GO_CYCLES(GO_CYCLES)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .go_req(go_req),
      .busy  (busy),
      .snap  (snap),
      .commit(commit)
   );

   assign go_busy = busy;

   // ---------------- divider slots ----------------
   logic [RATIO_W-1:0] sys_rd_ratio [NUM_SYS];
   logic               sys_rd_en    [NUM_SYS];
   logic [RATIO_W-1:0] fix_rd_ratio [NUM_FIX];
   logic               fix_rd_en    [NUM_FIX];

   for (genvar i = 0; i < NUM_SYS; i++) begin : g_sys
      clkgen_div_slot #(
         .RATIO_W(RATIO_W),
         .STAGED (1'b1)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_cyc & sys_hit[i]),
         .wr_ratio  (bus_wdata[RATIO_W-1:0]),
         .wr_enable (bus_wdata[ENA_BIT]),
         .snap      (snap),
         .commit    (commit),
         .rd_ratio  (sys_rd_ratio[i]),
         .rd_enable (sys_rd_en[i]),
         .divide    (sys_divide[i*DIV_W +: DIV_W]),
         .act_enable(sys_enable[i])
      );
   end

   for (genvar j = 0; j < NUM_FIX; j++) begin : g_fix
      clkgen_div_slot #(
         .RATIO_W(RATIO_W),
         .STAGED (1'b0)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_cyc & fix_hit[j]),
         .wr_ratio  (bus_wdata[RATIO_W-1:0]),
         .wr_enable (bus_wdata[ENA_BIT]),
         .snap      (snap),
         .commit    (commit),
         .rd_ratio  (fix_rd_ratio[j]),
         .rd_enable (fix_rd_en[j]),
         .divide    (fix_divide[j*DIV_W +: DIV_W]),
         .act_enable(fix_enable[j])
      );
   end

   // ---------------- plain registers ----------------
   logic [DATA_W-1:0] ctl_q;
   logic [OSEL_W-1:0] osel_q;
   logic [MULT_W-1:0] mult_q;
   logic [1:0]        cken_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         osel_q <= '0;
         mult_q <= '0;
         cken_q <= '0;
      end else if (wr_cyc) begin
         if (misc.ctl)  ctl_q  <= bus_wdata;
         if (misc.osel) osel_q <= bus_wdata[OSEL_W-1:0];
         if (misc.mult) mult_q <= bus_wdata[MULT_W-1:0];
         if (misc.cken) cken_q <= bus_wdata[1:0];
      end
   end

   assign aux_gate_en = cken_q[0];
   assign obs_gate_en = cken_q[1];

   clkgen_mult_calc #(
      .MULT_W     (MULT_W),
      .DOUBLE_MODE(DOUBLE_MODE)
   ) u_mult (
      .field (mult_q),
      .factor(mult_factor)
   );

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (misc.rev)  bus_rdata = DATA_W'(REV_ID);
      if (misc.ctl)  bus_rdata = ctl_q;
      if (misc.osel) bus_rdata[OSEL_W-1:0] = osel_q;
      if (misc.mult) bus_rdata[MULT_W-1:0] = mult_q;
      if (misc.stat) bus_rdata[0] = busy;
      if (misc.cken) bus_rdata[1:0] = cken_q;
      for (int i = 0; i < NUM_SYS; i++) begin
         if (sys_hit[i]) begin
            bus_rdata[RATIO_W-1:0] = sys_rd_ratio[i];
            bus_rdata[ENA_BIT]     = sys_rd_en[i];
         end
      end
      for (int j = 0; j < NUM_FIX; j++) begin
         if (fix_hit[j]) begin
            bus_rdata[RATIO_W-1:0] = fix_rd_ratio[j];
            bus_rdata[ENA_BIT]     = fix_rd_en[j];
         end
      end
   end

endmodule

// File: rtl/clkgen_div_bank_chk.sv
module clkgen_div_bank_chk
   import clkgen_div_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_SYS     = 9,
   parameter int unsigned RATIO_W     = 5,
   parameter int unsigned MULT_W      = 5,
   parameter int unsigned GO_CYCLES   = 8,
   parameter bit          DOUBLE_MODE = 1'b0
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           bus_sel,
   input logic                           bus_wr,
   input logic [ADDR_W-1:0]              bus_addr,
   input logic [RATIO_W-1:0]             wd_low,
   input logic [DATA_W-1:0]              bus_rdata,
   input logic [NUM_SYS*(RATIO_W+1)-1:0] sys_divide,
   input logic [NUM_SYS-1:0]             sys_enable,
   input logic [RATIO_W:0]               pre_divide,
   input logic [MULT_W:0]                mult_factor,
   input logic                           aux_gate_en,
   input logic                           obs_gate_en,
   input logic                           go_busy
);

   logic [31:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n)       run_len <= '0;
      else if (go_busy) run_len <= run_len + 1'b1;
      else              run_len <= '0;
   end

   // R5: accepted GO raises busy next cycle
   assert_go_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(W_CMD) && wd_low[0] && !go_busy)
      |=> go_busy);

   // R5, R7: the busy window is exactly GO_CYCLES long, even with repeated GO
   assert_go_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(go_busy) |-> (run_len == GO_CYCLES));

   // R4: active system outputs move only where a transfer ends
   assert_sys_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(go_busy) |-> ($stable(sys_divide) && $stable(sys_enable)));

   // R8: command reads zero, status mirrors busy
   assert_cmd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == ADDR_W'(W_CMD)) |-> (bus_rdata == '0));

   assert_stat_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == ADDR_W'(W_STAT))
      |-> (bus_rdata == DATA_W'(go_busy)));

   // R9: pre-divider follows its write on the next cycle
   assert_pre_direct_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(W_PRE))
      |=> (pre_divide == ({1'b0, $past(wd_low)} + 1'b1)));

   // R11: clock gates follow their bits
   assert_gates_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(W_CKEN))
      |=> (aux_gate_en == $past(wd_low[0]) && obs_gate_en == $past(wd_low[1])));

   if (!DOUBLE_MODE) begin : g_mult_chk
      // R10: multiplier output is field plus one
      assert_mult_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && !bus_wr && bus_addr == ADDR_W'(W_MULT))
         |-> (mult_factor == ({1'b0, bus_rdata[MULT_W-1:0]} + 1'b1)));
   end else begin : g_mult_dbl
      // R10 (alternate convention): factor is always even
      assert_mult_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
         mult_factor[0] == 1'b0);
   end

endmodule

bind clkgen_div_bank clkgen_div_bank_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .NUM_SYS    (NUM_SYS),
   .RATIO_W    (RATIO_W),
   .MULT_W     (MULT_W),
   .GO_CYCLES  (GO_CYCLES),
   .DOUBLE_MODE(DOUBLE_MODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .wd_low     (bus_wdata[RATIO_W-1:0]),
   .bus_rdata  (bus_rdata),
   .sys_divide (sys_divide),
   .sys_enable (sys_enable),
   .pre_divide (fix_divide[RATIO_W:0]),
   .mult_factor(mult_factor),
   .aux_gate_en(aux_gate_en),
   .obs_gate_en(obs_gate_en),
   .go_busy    (go_busy)
);

// File: tb/clkgen_div_bank_test.sv
module clkgen_div_bank_test;

   localparam int          NSYS = 9;
   localparam int          DW   = 6;
   localparam int          GOC  = 8;
   localparam logic [31:0] REV  = 32'h5C1A_0103;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NSYS*DW-1:0] sys_divide;
   logic [NSYS-1:0]   sys_enable;
   logic [4*DW-1:0]   fix_divide;
   logic [3:0]        fix_enable;
   logic [5:0]        mult_factor;
   logic              aux_gate_en, obs_gate_en, go_busy;

   int n_tests = 0;
   int n_fail  = 0;

   int exp_r [1:NSYS];
   int exp_e [1:NSYS];

   always #4 clk = ~clk;

   clkgen_div_bank #(
      .ADDR_W(8), .DATA_W(32), .NUM_SYS(NSYS), .RATIO_W(5), .MULT_W(5),
      .GO_CYCLES(GOC), .DOUBLE_MODE(1'b0), .REV_ID(REV)
   ) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sys_divide(sys_divide), .sys_enable(sys_enable),
      .fix_divide(fix_divide), .fix_enable(fix_enable),
      .mult_factor(mult_factor), .aux_gate_en(aux_gate_en),
      .obs_gate_en(obs_gate_en), .go_busy(go_busy)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] sysw(input int id);
      int b;
      b = (id < 4) ? ('h118 + 4 * (id - 1)) : ('h160 + 4 * (id - 4));
      return 8'(b >> 2);
   endfunction

   // drive at a falling edge, one clock per write
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (go_busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic check_sys_outputs(input string req);
      for (int id = 1; id <= NSYS; id++) begin
         chk(req, $sformatf("divide of sysdiv %0d", id),
             32'(sys_divide[(id-1)*DW +: DW]), 32'(exp_r[id] + 1));
         chk(req, $sformatf("enable of sysdiv %0d", id),
             32'(sys_enable[id-1]), 32'(exp_e[id]));
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int id = 1; id <= NSYS; id++) begin
         rd(sysw(id), d);
         chk("R1", "sysdiv readback after reset", d, 32'h0000_8000);
         exp_r[id] = 0; exp_e[id] = 1;
      end
      check_sys_outputs("R1");
      for (int k = 0; k < 4; k++) begin
         chk("R1", "aux divider output", 32'(fix_divide[k*DW +: DW]), 32'd1);
         chk("R1", "aux divider enable", 32'(fix_enable[k]), 32'd1);
      end
      rd(8'h45, d); chk("R1", "pre readback", d, 32'h0000_8000);
      rd(8'h44, d); chk("R1", "mult field", d, 32'd0);
      chk("R1", "mult factor", 32'(mult_factor), 32'd1);
      chk("R1", "gates", {30'd0, obs_gate_en, aux_gate_en}, 32'd0);
      chk("R1", "busy", 32'(go_busy), 32'd0);
   endtask

   task automatic t_map();
      logic [31:0] d;
      for (int id = 1; id <= NSYS; id++) begin
         wr(sysw(id), 32'h0000_8000 | 32'(id + 10));
         exp_r[id] = id + 10; exp_e[id] = 1;
      end
      for (int id = 1; id <= NSYS; id++) begin
         rd(sysw(id), d);
         chk("R2", $sformatf("sysdiv %0d own value", id), d, 32'h0000_8000 | 32'(id + 10));
      end
      wr(8'h40, 32'hA5A5_5A5A);
      rd(8'h40, d); chk("R13", "control readback", d, 32'hA5A5_5A5A);
      wr(8'h41, 32'hFFFF_FFFF);
      rd(8'h41, d); chk("R13", "observe select readback", d, 32'h0000_001F);
      rd(8'h00, d); chk("R13", "revision", d, REV);
   endtask

   task automatic t_format();
      logic [31:0] d;
      wr(sysw(1), 32'hFFFF_FFFF);
      rd(sysw(1), d); chk("R3", "all-ones keeps ratio and enable only", d, 32'h0000_801F);
      wr(sysw(1), 32'h0000_0013);
      rd(sysw(1), d); chk("R3", "enable cleared", d, 32'h0000_0013);
      exp_r[1] = 'h13; exp_e[1] = 0;
      wr(sysw(9), 32'h7FE0_0004);
      rd(sysw(9), d); chk("R3", "bit 15 clear, high bits dropped", d, 32'h0000_0004);
      exp_r[9] = 4; exp_e[9] = 0;
   endtask

   task automatic t_shadow();
      for (int id = 1; id <= NSYS; id++) begin
         chk("R4", "output still at reset before GO",
             32'(sys_divide[(id-1)*DW +: DW]), 32'd1);
         chk("R4", "enable still at reset before GO", 32'(sys_enable[id-1]), 32'd1);
      end
   endtask

   task automatic t_go();
      logic [31:0] d;
      int n;
      wr(8'h4E, 32'h0000_0001);
      chk("R5", "busy after GO", 32'(go_busy), 32'd1);
      rd(8'h4F, d); chk("R8", "status while busy", d, 32'd1);
      rd(8'h4E, d); chk("R8", "command reads zero", d, 32'd0);
      chk("R4", "sysdiv 2 held during transfer", 32'(sys_divide[DW +: DW]), 32'd1);
      wait_idle(n);
      chk("R5", "busy length", 32'(n + 0), 32'(GOC));
      rd(8'h4F, d); chk("R8", "status idle", d, 32'd0);
      check_sys_outputs("R5");
      chk("R3", "sysdiv 1 divide is ratio plus one", 32'(sys_divide[0 +: DW]), 32'h14);
   endtask

   task automatic t_mid();
      logic [31:0] d;
      int n;
      wr(sysw(2), 32'h0000_8000 | 32'd20);
      wr(8'h4E, 32'h0000_0001);
      wr(sysw(2), 32'h0000_8000 | 32'd25);
      wr(8'h4E, 32'h0000_0001);
      wait_idle(n);
      chk("R7", "repeat GO does not extend window", 32'(n), 32'(GOC - 2));
      chk("R6", "committed value predates mid-transfer write",
          32'(sys_divide[DW +: DW]), 32'd21);
      rd(sysw(2), d); chk("R6", "mid-transfer write in readback", d, 32'h0000_8019);
      wr(8'h4E, 32'h0000_0001);
      wait_idle(n);
      chk("R6", "mid-transfer write applied by next GO", 32'(sys_divide[DW +: DW]), 32'd26);
   endtask

   task automatic t_fix();
      logic [31:0] d;
      wr(8'h45, 32'h0000_8007);
      chk("R9", "pre divide", 32'(fix_divide[0 +: DW]), 32'd8);
      chk("R9", "pre enable", 32'(fix_enable[0]), 32'd1);
      wr(8'h4A, 32'h0000_0003);
      chk("R9", "post divide", 32'(fix_divide[DW +: DW]), 32'd4);
      chk("R9", "post enable", 32'(fix_enable[1]), 32'd0);
      wr(8'h49, 32'h0000_801E);
      chk("R9", "osc divide", 32'(fix_divide[2*DW +: DW]), 32'd31);
      wr(8'h4B, 32'h0000_8009);
      chk("R9", "bypass divide", 32'(fix_divide[3*DW +: DW]), 32'd10);
      rd(8'h4A, d); chk("R9", "post readback", d, 32'h0000_0003);
      chk("R9", "no transfer started", 32'(go_busy), 32'd0);
   endtask

   task automatic t_mult();
      logic [31:0] d;
      wr(8'h44, 32'h0000_0013);
      chk("R10", "factor field+1", 32'(mult_factor), 32'h14);
      rd(8'h44, d); chk("R10", "mult readback", d, 32'h13);
      wr(8'h44, 32'hFFFF_FFFF);
      rd(8'h44, d); chk("R10", "mult upper bits zero", d, 32'h1F);
      chk("R10", "factor at max field", 32'(mult_factor), 32'd32);
   endtask

   task automatic t_cken();
      logic [31:0] d;
      wr(8'h52, 32'h0000_0002);
      chk("R11", "obs only", {30'd0, obs_gate_en, aux_gate_en}, 32'd2);
      wr(8'h52, 32'h0000_0001);
      chk("R11", "aux only", {30'd0, obs_gate_en, aux_gate_en}, 32'd1);
      wr(8'h52, 32'hFFFF_FFFF);
      chk("R11", "both", {30'd0, obs_gate_en, aux_gate_en}, 32'd3);
      rd(8'h52, d); chk("R11", "gate readback", d, 32'd3);
   endtask

   task automatic t_undef();
      logic [31:0] d;
      rd(8'h42, d); chk("R12", "unmapped read", d, 32'd0);
      wr(8'h42, 32'hFFFF_FFFF);
      wr(8'h50, 32'hFFFF_FFFF);
      wr(8'h5E, 32'hFFFF_FFFF);
      wr(8'h01, 32'hFFFF_FFFF);
      rd(8'h42, d); chk("R12", "unmapped 0x108 after write", d, 32'd0);
      rd(8'h50, d); chk("R12", "unmapped 0x140 after write", d, 32'd0);
      rd(8'h5E, d); chk("R12", "unmapped 0x178 after write", d, 32'd0);
      rd(8'h40, d); chk("R12", "control untouched", d, 32'hA5A5_5A5A);
      rd(sysw(1), d); chk("R12", "sysdiv 1 untouched", d, 32'h0000_0013);
      rd(8'h45, d); chk("R12", "pre untouched", d, 32'h0000_8007);
      chk("R12", "mult factor untouched", 32'(mult_factor), 32'd32);
      chk("R12", "busy untouched", 32'(go_busy), 32'd0);
      check_sys_outputs("R12");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map();
      t_format();
      t_shadow();
      t_go();
      exp_r[2] = 25;
      t_mid();
      t_fix();
      t_mult();
      t_cken();
      t_undef();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule